// File: doc/BRIEF.md
# Register-Mapped Integer Divider

This block divides one 32-bit integer by another and returns both quotient and remainder through a small register port. Software writes the two operands and polls a status word. It then reads back the remainder and the quotient. Every operand write restarts the division. The address used for the write decides whether the operands are treated as two's-complement or as unsigned values. Each operand register can be reached at one address of each kind.

The division is sequential. A chain of restoring steps retires four quotient bits per clock, so a 32-bit result is ready eight cycles after the last operand write. For context switches, software can write the quotient and the remainder registers directly. Such a write cancels any division in progress and marks the result as valid and not yet consumed. A "dirty" flag tells a restore routine whether a result is waiting. An operand write or a direct result write sets it. A read of the quotient clears it, so the remainder should be read first.

Top module: `mmio_divider`

## Requirements
- R1: In unsigned mode, after completion, the quotient register (word address 4) holds floor(dividend / divisor) and the remainder register (word address 5) holds dividend mod divisor, for a non-zero divisor.
- R2: In signed mode, the quotient is truncated toward zero. It is negative when the operand signs differ. The remainder takes the dividend's sign, and magnitude remainder < |divisor|. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R3: After an operand write, READY reads 0 for exactly 8 clock cycles. It reads 1 after the 8th rising edge following the write edge.
- R4: A new operand write during a division restarts it. The result then depends only on the latest write and the stored value of the other operand. The 8-cycle count starts again from that write.
- R5: Word addresses 0 (dividend) and 1 (divisor) start an unsigned division. Word addresses 2 (dividend) and 3 (divisor) start a signed one. The same operand bits give mode-dependent results.
- R6: A write to address 4 or 5 loads that result register, stops any division in progress, and sets READY and DIRTY in the next cycle. The written value is not overwritten later by the cancelled division.
- R7: An operand write sets DIRTY. A read (rd_en high, wr_en low) of address 4 clears DIRTY at that clock edge. A read of address 5 leaves DIRTY unchanged.
- R8: With a zero divisor, the remainder equals the dividend. The unsigned quotient is 0xFFFFFFFF. The signed quotient is 0xFFFFFFFF (-1) for a non-negative dividend and 1 for a negative dividend.
- R9: The status word at address 6 returns READY in bit 0 and DIRTY in bit 1, with all other bits zero.
- R10: After reset, READY is 1, DIRTY is 0, and both operands and both results read 0.
- R11: An operand reads back its stored value at both of its addresses, whichever address wrote it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| rd_en | input | 1 | Register read strobe; only matters for the quotient address |
| addr | input | 3 | Word address: 0/1 unsigned dividend/divisor, 2/3 signed dividend/divisor, 4 quotient, 5 remainder, 6 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |

## Verification
Unsigned operands are tried with small exact values, with values that leave a remainder, and with dividends that have the top bit set. The last case shows whether the top operand bit is carried as magnitude rather than sign. Signed operands cover all four sign pairings and the -2^31 / -1 overflow case, which show separately whether the quotient sign and the remainder sign rules hold. One bit pattern is sent through both alias addresses, and the difference shows that the alias, not the data, picks the mode. A zero divisor in both modes shows the saturating quotient and the pass-through remainder.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DVD_U = 3'd0,
        SEL_DVS_U = 3'd1,
        SEL_DVD_S = 3'd2,
        SEL_DVS_S = 3'd3,
        SEL_QUO   = 3'd4,
        SEL_REM   = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/mdiv_step.sv
// Combinational chain of BPC restoring-division steps on magnitudes.
module mdiv_step #(
    parameter int W   = 32,
    parameter int BPC = 4
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);

    logic [W-1:0] part_rem [BPC+1];
    logic [W-1:0] part_quo [BPC+1];

    assign part_rem[0] = rem_i;
    assign part_quo[0] = quo_i;

    for (genvar i = 0; i < BPC; i++) begin : g_bit
        logic [W:0] shifted;
        logic       fits;
        assign shifted         = {part_rem[i], part_quo[i][W-1]};
        assign fits            = shifted >= {1'b0, den_i};
        assign part_rem[i+1]   = fits ? W'(shifted - {1'b0, den_i}) : shifted[W-1:0];
        assign part_quo[i+1]   = {part_quo[i][W-2:0], fits};
    end

    assign rem_o = part_rem[BPC];
    assign quo_o = part_quo[BPC];

endmodule

// File: rtl/mdiv_sign_fix.sv
// Applies the signed-mode result signs to magnitude results.
module mdiv_sign_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_abs_i,
    input  logic [W-1:0] rem_abs_i,
    input  logic         qneg_i,
    input  logic         rneg_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    assign quo_o = qneg_i ? (~quo_abs_i + W'(1)) : quo_abs_i;
    assign rem_o = rneg_i ? (~rem_abs_i + W'(1)) : rem_abs_i;

endmodule

// File: rtl/mmio_divider.sv
module mmio_divider
    import mdiv_pkg::*;
#(
    parameter int W   = 32,
    parameter int BPC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata
);

    localparam int CYC   = W / BPC;
    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

    typedef struct packed {
        logic [W-1:0]     dvd;
        logic [W-1:0]     dvs;
        logic [W-1:0]     quo;    // working quotient while busy, result after
        logic [W-1:0]     rem;    // working remainder while busy, result after
        logic [W-1:0]     den;    // divisor magnitude
        logic             qneg;
        logic             rneg;
        logic             busy;
        logic             dirty;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_q, s_d;

    reg_sel_e sel;
    logic     wr_dvd, wr_dvs, op_wr, sgn_wr, res_wr, quo_rd, ready;
    logic [W-1:0] new_dvd, new_dvs, dvd_abs, dvs_abs;
    logic [W-1:0] step_rem, step_quo, fix_quo, fix_rem;

    assign sel    = reg_sel_e'(addr);
    assign wr_dvd = wr_en && (sel == SEL_DVD_U || sel == SEL_DVD_S);
    assign wr_dvs = wr_en && (sel == SEL_DVS_U || sel == SEL_DVS_S);
    assign op_wr  = wr_dvd || wr_dvs;
    assign sgn_wr = wr_en && (sel == SEL_DVD_S || sel == SEL_DVS_S);
    assign res_wr = wr_en && (sel == SEL_QUO || sel == SEL_REM);
    assign quo_rd = rd_en && !wr_en && (sel == SEL_QUO);
    assign ready  = !s_q.busy;

    assign new_dvd = wr_dvd ? wdata : s_q.dvd;
    assign new_dvs = wr_dvs ? wdata : s_q.dvs;
    assign dvd_abs = (sgn_wr && new_dvd[W-1]) ? (~new_dvd + W'(1)) : new_dvd;
    assign dvs_abs = (sgn_wr && new_dvs[W-1]) ? (~new_dvs + W'(1)) : new_dvs;

    mdiv_step #(.W(W), .BPC(BPC)) u_step (
        .rem_i (s_q.rem),
        .quo_i (s_q.quo),
        .den_i (s_q.den),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    mdiv_sign_fix #(.W(W)) u_fix (
        .quo_abs_i (step_quo),
        .rem_abs_i (step_rem),
        .qneg_i    (s_q.qneg),
        .rneg_i    (s_q.rneg),
        .quo_o     (fix_quo),
        .rem_o     (fix_rem)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            s_d.quo = step_quo;
            s_d.rem = step_rem;
            s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.quo  = fix_quo;
                s_d.rem  = fix_rem;
            end
        end
        if (quo_rd) begin
            s_d.dirty = 1'b0;
        end
        if (op_wr) begin
            s_d.dvd   = new_dvd;
            s_d.dvs   = new_dvs;
            s_d.quo   = dvd_abs;
            s_d.rem   = '0;
            s_d.den   = dvs_abs;
            s_d.qneg  = sgn_wr && (new_dvd[W-1] ^ new_dvs[W-1]);
            s_d.rneg  = sgn_wr && new_dvd[W-1];
            s_d.busy  = 1'b1;
            s_d.cnt   = '0;
            s_d.dirty = 1'b1;
        end
        if (res_wr) begin
            s_d.busy  = 1'b0;
            s_d.dirty = 1'b1;
            if (sel == SEL_QUO) s_d.quo = wdata;
            else                s_d.rem = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (sel)
            SEL_DVD_U, SEL_DVD_S: rdata = s_q.dvd;
            SEL_DVS_U, SEL_DVS_S: rdata = s_q.dvs;
            SEL_QUO:              rdata = s_q.quo;
            SEL_REM:              rdata = s_q.rem;
            SEL_STAT:             rdata = {{(W-2){1'b0}}, s_q.dirty, ready};
            default:              rdata = '0;
        endcase
    end

    // Operand write drops READY on the following cycle (R3)
    assert_start_drops_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> !ready);

    // Final step of an undisturbed division raises READY (R3)
    assert_ready_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt == LAST && !op_wr) |=> ready);

    // Direct result write leaves the block ready and dirty (R6)
    assert_result_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |=> (ready && s_q.dirty));

    // Operand write marks the result dirty (R7)
    assert_op_sets_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> s_q.dirty);

    // Quotient read consumes the result (R7)
    assert_quo_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        quo_rd |=> !s_q.dirty);

endmodule

// File: tb/test_mmio_divider.sv
`timescale 1ns/1ps
module test_mmio_divider;
    import mdiv_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    mmio_divider i_mmio_divider (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic model(input logic [31:0] a, input logic [31:0] b, input bit sgn,
                         output logic [31:0] q, output logic [31:0] r);
        longint sa;
        longint sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (b == 32'd0) begin
            q = sgn ? (a[31] ? 32'd1 : 32'hFFFF_FFFF) : 32'hFFFF_FFFF;
            r = a;
        end else if (!sgn) begin
            q = a / b;
            r = a % b;
        end else begin
            q = 32'(sa / sb);
            r = 32'(sa % sb);
        end
    endtask

    task automatic run_case(input logic [31:0] a, input logic [31:0] b, input bit sgn,
                            input string req);
        logic [31:0] q, r, eq, er;
        wr(sgn ? 3'(SEL_DVD_S) : 3'(SEL_DVD_U), a);
        wr(sgn ? 3'(SEL_DVS_S) : 3'(SEL_DVS_U), b);
        repeat (8) @(negedge clk);
        rd(3'(SEL_REM), r);
        rd(3'(SEL_QUO), q);
        model(a, b, sgn, eq, er);
        check({req, " quotient"}, q, eq);
        check({req, " remainder"}, r, er);
    endtask

    task automatic test_reset_R10();
        logic [31:0] v;
        peek(3'(SEL_STAT), v); check("R10 status", v, 32'h1);
        peek(3'(SEL_QUO), v);  check("R10 quotient", v, 32'h0);
        peek(3'(SEL_REM), v);  check("R10 remainder", v, 32'h0);
        peek(3'(SEL_DVD_U), v); check("R10 dividend", v, 32'h0);
    endtask

    task automatic test_unsigned_R1();
        run_case(32'd100, 32'd10, 1'b0, "R1");
        run_case(32'd1000, 32'd7, 1'b0, "R1");
        run_case(32'hF000_0001, 32'd3, 1'b0, "R1");
        run_case(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, "R1");
        run_case(32'd5, 32'd9, 1'b0, "R1");
    endtask

    task automatic test_signed_R2();
        run_case(-32'sd7, 32'sd2, 1'b1, "R2");
        run_case(32'sd7, -32'sd2, 1'b1, "R2");
        run_case(-32'sd7, -32'sd2, 1'b1, "R2");
        run_case(32'sd7, 32'sd2, 1'b1, "R2");
        run_case(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R2");
    endtask

    task automatic test_alias_R5();
        logic [31:0] q, r;
        wr(3'(SEL_DVD_U), 32'hFFFF_FFF0);
        wr(3'(SEL_DVS_U), 32'd3);
        repeat (8) @(negedge clk);
        rd(3'(SEL_REM), r); rd(3'(SEL_QUO), q);
        check("R5 unsigned quotient", q, 32'h5555_5550);
        check("R5 unsigned remainder", r, 32'h0);
        wr(3'(SEL_DVS_S), 32'd3);
        repeat (8) @(negedge clk);
        rd(3'(SEL_REM), r); rd(3'(SEL_QUO), q);
        check("R5 signed quotient", q, 32'hFFFF_FFFB);
        check("R5 signed remainder", r, 32'hFFFF_FFFF);
    endtask

    task automatic test_timing_R3();
        logic [31:0] v;
        wr(3'(SEL_DVD_U), 32'd1000);
        wr(3'(SEL_DVS_U), 32'd7);
        peek(3'(SEL_STAT), v); check("R3 busy after write", v, 32'h2);
        repeat (7) @(negedge clk);
        peek(3'(SEL_STAT), v); check("R3 busy at cycle 7", v, 32'h2);
        @(negedge clk);
        peek(3'(SEL_STAT), v); check("R3 ready at cycle 8", v, 32'h3);
        peek(3'(SEL_QUO), v);  check("R3 quotient", v, 32'd142);
    endtask

    task automatic test_restart_R4();
        logic [31:0] v;
        wr(3'(SEL_DVD_U), 32'd100);
        wr(3'(SEL_DVS_U), 32'd7);
        repeat (3) @(negedge clk);
        wr(3'(SEL_DVS_U), 32'd9);
        repeat (7) @(negedge clk);
        peek(3'(SEL_STAT), v); check("R4 still busy after restart", v & 32'h1, 32'h0);
        @(negedge clk);
        peek(3'(SEL_STAT), v); check("R4 ready after restart", v & 32'h1, 32'h1);
        peek(3'(SEL_QUO), v);  check("R4 quotient", v, 32'd11);
        peek(3'(SEL_REM), v);  check("R4 remainder", v, 32'd1);
    endtask

    task automatic test_abort_R6();
        logic [31:0] v;
        wr(3'(SEL_DVD_U), 32'd500);
        wr(3'(SEL_DVS_U), 32'd3);
        repeat (2) @(negedge clk);
        wr(3'(SEL_QUO), 32'h0000_1234);
        peek(3'(SEL_STAT), v); check("R6 ready and dirty", v, 32'h3);
        repeat (12) @(negedge clk);
        peek(3'(SEL_QUO), v); check("R6 quotient kept", v, 32'h0000_1234);
        wr(3'(SEL_REM), 32'h0000_ABCD);
        peek(3'(SEL_REM), v); check("R6 remainder loaded", v, 32'h0000_ABCD);
        peek(3'(SEL_QUO), v); check("R6 quotient untouched", v, 32'h0000_1234);
    endtask

    task automatic test_dirty_R7_R9();
        logic [31:0] v;
        wr(3'(SEL_DVD_U), 32'd50);
        wr(3'(SEL_DVS_U), 32'd5);
        repeat (8) @(negedge clk);
        peek(3'(SEL_STAT), v); check("R9 status ready+dirty", v, 32'h3);
        rd(3'(SEL_REM), v);
        peek(3'(SEL_STAT), v); check("R7 remainder read keeps dirty", v, 32'h3);
        rd(3'(SEL_QUO), v);    check("R7 quotient value", v, 32'd10);
        peek(3'(SEL_STAT), v); check("R7 quotient read clears dirty", v, 32'h1);
    endtask

    task automatic test_divzero_R8();
        run_case(32'd1234, 32'd0, 1'b0, "R8");
        run_case(-32'sd7, 32'd0, 1'b1, "R8");
        run_case(32'sd7, 32'd0, 1'b1, "R8");
    endtask

    task automatic test_readback_R11();
        logic [31:0] v;
        wr(3'(SEL_DVS_S), 32'h0000_0011);
        wr(3'(SEL_DVD_U), 32'hCAFE_0001);
        peek(3'(SEL_DVD_S), v); check("R11 dividend at signed alias", v, 32'hCAFE_0001);
        peek(3'(SEL_DVS_U), v); check("R11 divisor at unsigned alias", v, 32'h0000_0011);
        repeat (8) @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20.0 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset_R10();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_R10();
        test_unsigned_R1();
        test_signed_R2();
        test_alias_R5();
        test_timing_R3();
        test_restart_R4();
        test_abort_R6();
        test_dirty_R7_R9();
        test_divzero_R8();
        test_readback_R11();
        report();
        $finish;
    end

endmodule